// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block turns one instruction word of a single-cycle computer into the complete set of control signals for that cycle. It is purely combinational. Every output follows the instruction input within the same cycle. The block drives the three register-file addresses, the operand and write-back multiplexer selects, the register and memory write enables, and the four-bit function select. It also drives the three signals that tell program-counter logic whether to step, jump or branch, and which flag a branch tests.

The instruction word has a seven-bit opcode at the top. Below it sit three register fields: the destination, source A, and source B. The source B field doubles as a three-bit immediate. The two most significant opcode bits pick one of four instruction classes, and the class sets the enables: register-to-register ALU, store, immediate ALU, and program-flow. The load, store, add, add-immediate, complement and increment instructions all fit this layout.

One opcode bit serves two purposes. It is the low bit of the function select and also the branch-condition select. The decoder forces the function-select low bit to zero for program-flow instructions. This lets a branch on zero pass register A to the flags unchanged.

Top module: `instr_decoder`

## Requirements
- R1: `dst_addr`, `a_addr` and `b_addr` equal instruction bits 8:6, 5:3 and 2:0 respectively.
- R2: `b_sel_const` (1 = immediate, 0 = register B) equals instruction bit 15.
- R3: `d_sel_mem` (1 = memory data, 0 = function-unit result) equals instruction bit 13.
- R4: `reg_wr` is high exactly when instruction bit 14 is low.
- R5: `mem_wr` is high exactly when bit 14 is high and bit 15 is low (store class).
- R6: `pc_load` is high exactly when bits 15 and 14 are both high (program-flow class); otherwise the counter steps.
- R7: `jump_sel` equals bit 13: 1 = unconditional jump, 0 = conditional branch.
- R8: `br_cond` equals bit 9: 1 = the branch tests the zero flag, 0 = it tests the negative flag.
- R9: `fn_sel[3:1]` equals instruction bits 12:10.
- R10: `fn_sel[0]` equals bit 9 when `pc_load` is low and is forced to 0 when `pc_load` is high.
- R11: `imm_val` is bits 2:0 zero-filled to `DATA_W` bits.
- R12: `reg_wr` and `mem_wr` are never both high, and neither is high while `pc_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| dst_addr | output | 3 | Destination register address |
| a_addr | output | 3 | Source A register address |
| b_addr | output | 3 | Source B register address |
| imm_val | output | DATA_W | Zero-filled immediate operand |
| b_sel_const | output | 1 | Operand B select: immediate when 1 |
| d_sel_mem | output | 1 | Write-back select: memory data when 1 |
| reg_wr | output | 1 | Register file write enable |
| mem_wr | output | 1 | Data memory write enable |
| fn_sel | output | 4 | Function-unit operation select |
| pc_load | output | 1 | Load the program counter instead of stepping |
| jump_sel | output | 1 | Jump when 1, conditional branch when 0 |
| br_cond | output | 1 | Branch flag select: zero when 1, negative when 0 |

## Verification
Two functions can claim the same instruction bit in one cycle: branch-condition selection and function selection. A collision happens on any program-flow instruction whose bit 9 is set. The bench provokes this with a directed branch-on-zero opcode. It then sweeps every instruction word, so each value of bits 12:10 meets bit 9 set in every class. In each cycle it judges the collision by requiring `br_cond` to carry bit 9. In the same cycle it requires `fn_sel[0]` to stay at zero for the program-flow class, and to follow bit 9 in every other class.

// File: rtl/instr_decoder_pkg.sv
package instr_decoder_pkg;

    // Width of the opcode field at the top of the instruction word
    localparam int OPC_W = 7;

    // Instruction class taken from the two most significant opcode bits
    typedef enum logic [1:0] {
        CLS_ALU   = 2'b00,
        CLS_STORE = 2'b01,
        CLS_IMM   = 2'b10,
        CLS_FLOW  = 2'b11
    } instr_class_t;

endpackage

// File: rtl/instr_field_split.sv
module instr_field_split #(
    parameter int REG_AW  = 3,
    parameter int INSTR_W = instr_decoder_pkg::OPC_W + 3 * REG_AW
) (
    input  logic [INSTR_W-1:0]                  instr,
    output logic [instr_decoder_pkg::OPC_W-1:0] opcode,
    output logic [REG_AW-1:0]                   dst_fld,
    output logic [REG_AW-1:0]                   a_fld,
    output logic [REG_AW-1:0]                   b_fld
);
    localparam int B_LO = 0;
    localparam int A_LO = REG_AW;
    localparam int D_LO = 2 * REG_AW;
    localparam int O_LO = 3 * REG_AW;

    always_comb begin
        b_fld   = instr[B_LO +: REG_AW];
        a_fld   = instr[A_LO +: REG_AW];
        dst_fld = instr[D_LO +: REG_AW];
        opcode  = instr[O_LO +: instr_decoder_pkg::OPC_W];
    end
endmodule

// File: rtl/ctrl_class_decode.sv
module ctrl_class_decode
    import instr_decoder_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             b_sel_const,
    output logic             d_sel_mem,
    output logic             reg_wr,
    output logic             mem_wr,
    output logic             pc_load,
    output logic             jump_sel
);
    instr_class_t cls;

    always_comb begin
        cls = instr_class_t'(opcode[OPC_W-1 -: 2]);
    end

    always_comb begin
        b_sel_const = 1'b0;
        reg_wr      = 1'b0;
        mem_wr      = 1'b0;
        pc_load     = 1'b0;
        unique case (cls)
            CLS_ALU: begin
                reg_wr = 1'b1;
            end
            CLS_STORE: begin
                mem_wr = 1'b1;
            end
            CLS_IMM: begin
                b_sel_const = 1'b1;
                reg_wr      = 1'b1;
            end
            CLS_FLOW: begin
                b_sel_const = 1'b1;
                pc_load     = 1'b1;
            end
            default: begin
                reg_wr = 1'b0;
            end
        endcase
        // The third opcode bit picks memory write-back and jump alike
        d_sel_mem = opcode[OPC_W-3];
        jump_sel  = opcode[OPC_W-3];
    end
endmodule

// File: rtl/fn_select_gen.sv
module fn_select_gen
    import instr_decoder_pkg::*;
#(
    parameter int FS_W = 4
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic             pc_load,
    output logic [FS_W-1:0]  fn_sel,
    output logic             br_cond
);
    always_comb begin
        fn_sel[FS_W-1:1] = opcode[FS_W-1:1];
        // Shared bit: operation select for data classes, flag select for flow
        fn_sel[0] = opcode[0] & ~pc_load;
        br_cond   = opcode[0];
    end
endmodule

// File: rtl/imm_zero_fill.sv
module imm_zero_fill #(
    parameter int SRC_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic [SRC_W-1:0]  src,
    output logic [DATA_W-1:0] dst
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < SRC_W) begin : g_copy
            assign dst[i] = src[i];
        end else begin : g_zero
            assign dst[i] = 1'b0;
        end
    end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder #(
    parameter int DATA_W  = 16,
    parameter int REG_AW  = 3,
    parameter int FS_W    = 4,
    parameter int INSTR_W = instr_decoder_pkg::OPC_W + 3 * REG_AW
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [REG_AW-1:0]  dst_addr,
    output logic [REG_AW-1:0]  a_addr,
    output logic [REG_AW-1:0]  b_addr,
    output logic [DATA_W-1:0]  imm_val,
    output logic               b_sel_const,
    output logic               d_sel_mem,
    output logic               reg_wr,
    output logic               mem_wr,
    output logic [FS_W-1:0]    fn_sel,
    output logic               pc_load,
    output logic               jump_sel,
    output logic               br_cond
);
    logic [instr_decoder_pkg::OPC_W-1:0] opcode;

    instr_field_split #(
        .REG_AW  (REG_AW),
        .INSTR_W (INSTR_W)
    ) u_split (
        .instr   (instr),
        .opcode  (opcode),
        .dst_fld (dst_addr),
        .a_fld   (a_addr),
        .b_fld   (b_addr)
    );

    ctrl_class_decode u_class (
        .opcode      (opcode),
        .b_sel_const (b_sel_const),
        .d_sel_mem   (d_sel_mem),
        .reg_wr      (reg_wr),
        .mem_wr      (mem_wr),
        .pc_load     (pc_load),
        .jump_sel    (jump_sel)
    );

    fn_select_gen #(
        .FS_W (FS_W)
    ) u_fs (
        .opcode  (opcode),
        .pc_load (pc_load),
        .fn_sel  (fn_sel),
        .br_cond (br_cond)
    );

    imm_zero_fill #(
        .SRC_W  (REG_AW),
        .DATA_W (DATA_W)
    ) u_imm (
        .src (b_addr),
        .dst (imm_val)
    );
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 3,
    parameter int FS_W   = 4
) (
    input logic [DATA_W-1:0] imm_val,
    input logic [REG_AW-1:0] b_addr,
    input logic              b_sel_const,
    input logic              reg_wr,
    input logic              mem_wr,
    input logic [FS_W-1:0]   fn_sel,
    input logic              pc_load
);
    always_comb begin
        // R12
        wr_excl_chk: assert (!(reg_wr && mem_wr))
            else $error("register and memory write both active");
        // R12
        flow_no_wr_chk: assert (!(pc_load && (reg_wr || mem_wr)))
            else $error("write enable active on program-flow instruction");
        // R10
        fs0_mask_chk: assert (!(pc_load && fn_sel[0]))
            else $error("function select low bit not masked on flow");
        // R11
        imm_fill_chk: assert (imm_val == DATA_W'(b_addr))
            else $error("immediate not zero-filled");
        // R2
        store_reg_b_chk: assert (!(mem_wr && b_sel_const))
            else $error("store selects immediate operand");
    end
endmodule

bind instr_decoder instr_decoder_chk #(
    .DATA_W (DATA_W),
    .REG_AW (REG_AW),
    .FS_W   (FS_W)
) u_chk (
    .imm_val     (imm_val),
    .b_addr      (b_addr),
    .b_sel_const (b_sel_const),
    .reg_wr      (reg_wr),
    .mem_wr      (mem_wr),
    .fn_sel      (fn_sel),
    .pc_load     (pc_load)
);

// File: tb/sim_instr_decoder.sv
`timescale 1ns/1ps
module sim_instr_decoder;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;

    logic [2:0]        dst_addr, a_addr, b_addr;
    logic [DATA_W-1:0] imm_val;
    logic              b_sel_const, d_sel_mem, reg_wr, mem_wr;
    logic [3:0]        fn_sel;
    logic              pc_load, jump_sel, br_cond;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    instr_decoder #(.DATA_W(DATA_W)) u0 (
        .instr       (instr),
        .dst_addr    (dst_addr),
        .a_addr      (a_addr),
        .b_addr      (b_addr),
        .imm_val     (imm_val),
        .b_sel_const (b_sel_const),
        .d_sel_mem   (d_sel_mem),
        .reg_wr      (reg_wr),
        .mem_wr      (mem_wr),
        .fn_sel      (fn_sel),
        .pc_load     (pc_load),
        .jump_sel    (jump_sel),
        .br_cond     (br_cond)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s instr=%h actual=%0d expected=%0d", tag, instr, actual, expected);
        end
    endtask

    // Behavioural reference: every output worked out from the requirement text
    task automatic compare_all();
        int w, top2, bit13, bit9, flow;
        w     = int'(instr);
        top2  = w / 16384;
        bit13 = (w / 8192) % 2;
        bit9  = (w / 512) % 2;
        flow  = (top2 == 3) ? 1 : 0;
        check("R1 dst", int'(dst_addr), (w / 64) % 8);
        check("R1 a",   int'(a_addr),   (w / 8) % 8);
        check("R1 b",   int'(b_addr),   w % 8);
        check("R2",  int'(b_sel_const), top2 / 2);
        check("R3",  int'(d_sel_mem), bit13);
        check("R4",  int'(reg_wr), (top2 % 2 == 0) ? 1 : 0);
        check("R5",  int'(mem_wr), (top2 == 1) ? 1 : 0);
        check("R6",  int'(pc_load), flow);
        check("R7",  int'(jump_sel), bit13);
        check("R8",  int'(br_cond), bit9);
        check("R9",  int'(fn_sel) / 2, (w / 1024) % 8);
        check("R10", int'(fn_sel) % 2, flow ? 0 : bit9);
        check("R11", int'(imm_val), w % 8);
        check("R12", int'(reg_wr) + int'(mem_wr) + int'(pc_load) * 2, flow ? 2 : 1);
    endtask

    task automatic apply(logic [15:0] v);
        @(posedge clk);
        instr = v;
        @(negedge clk);
        compare_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset-phase word of zero: ALU class, add-nothing, register write
        check("R4 reset", int'(reg_wr), 1);
        check("R6 reset", int'(pc_load), 0);
        check("R5 reset", int'(mem_wr), 0);
        rst_n = 1'b1;

        // Named instructions: opcode << 9 | dr << 6 | sa << 3 | sb
        apply({7'b0010000, 3'd1, 3'd3, 3'd0}); // load
        check("R3 load", int'(d_sel_mem), 1);
        apply({7'b0100000, 3'd0, 3'd3, 3'd2}); // store
        check("R5 store", int'(mem_wr), 1);
        apply({7'b0000010, 3'd2, 3'd2, 3'd1}); // add
        check("R9 add", int'(fn_sel), 2);
        apply({7'b1000010, 3'd1, 3'd1, 3'd3}); // add immediate
        check("R11 addimm", int'(imm_val), 3);
        apply({7'b0001110, 3'd1, 3'd1, 3'd0}); // complement
        check("R9 not", int'(fn_sel), 14);
        apply({7'b0000001, 3'd3, 3'd3, 3'd0}); // increment
        check("R10 inc", int'(fn_sel), 1);
        apply({7'b1100001, 3'd0, 3'd4, 3'd5}); // branch on zero
        check("R10 brz", int'(fn_sel), 0);
        check("R8 brz", int'(br_cond), 1);
        apply({7'b1110000, 3'd0, 3'd6, 3'd0}); // jump
        check("R7 jump", int'(jump_sel), 1);

        // Exhaustive sweep, compared every clock
        for (int i = 0; i < 65536; i++) begin
            apply(16'(i));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule